// File: doc/BRIEF.md
# Two-Level Pending Interrupt Status Register

This block keeps the event status of a paging decoder where a host can read it. The host sees a primary status word and an interrupt line. An event is either a received call carrying status bits or a change of the out-of-range flag. If an event arrives while the primary word is still unread, or while a read is under way, the block does not overwrite the primary word. It places the event in a one-deep secondary stage instead. When the host finishes its read, the buffered word moves into the primary word and the interrupt fires again. Only the newest buffered event survives.

The out-of-range flag has two parts: a live flag and a reported flag. The live flag is set when the receiver enters fade recovery or carrier-off operation. It is cleared when a preamble or a valid sync word is detected. The reported flag is status bit `OOR_BIT`, and it copies the live flag only when the receiver is switched off. Any change in the reported flag is an event of its own.

Call events use a valid/ready input. The block never applies back-pressure: `call_ready` is always high, and every beat with `call_valid` high is taken on that clock edge. The read strobes, the detection strobes, the receiver enable and the interrupt are plain control pins.

Top module: `pend_irq_stat`

## Requirements
- R1: After reset, `stat_word` is all zeros and `irq` is low.
- R2: With no unread status and no read in progress, an event loads its word into `stat_word` on the next clock edge. `irq` rises one clock edge after that.
- R3: An event that arrives while the primary word is unread (after an event was loaded and before the next `rd_end`) goes to the secondary stage. `stat_word` stays unchanged.
- R4: An event in the `rd_start` cycle, or in any cycle after it up to the cycle before `rd_end`, goes to the secondary stage.
- R5: A `rd_end` with a buffered word copies that word into `stat_word` and empties the secondary stage. A second read right after it changes nothing.
- R6: `rd_start` drives `irq` low on the next edge. After a promotion, `irq` is low for exactly one clock and then goes high.
- R7: When several events are buffered, only the word of the most recent one is promoted.
- R8: A `rd_end` with nothing buffered keeps `stat_word` as it is and leaves `irq` low.
- R9: An event in the `rd_end` cycle is not lost. If a word was buffered, that word is promoted and the new event becomes the buffered word. If nothing was buffered, the new event loads `stat_word` directly, and `irq` rises one clock later.
- R10: The live out-of-range flag is set by `oor_enter` and cleared by `preamble_det` or `sync_det`. If `oor_enter` arrives in the same cycle as a clear, `oor_enter` wins.
- R11: Bit `OOR_BIT` of the reported status changes only on a clock where `rx_en` has just fallen from 1 to 0. A change raises an event whose word has only bit `OOR_BIT` carrying the new flag, with all other bits zero. A fall that leaves the flag unchanged raises no event.
- R12: A call word is `call_bits` with bit `OOR_BIT` replaced by the reported out-of-range flag. `call_ready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_valid | input | 1 | A call status beat is present |
| call_ready | output | 1 | Always 1; the block never stalls calls |
| call_bits | input | STAT_W | Status bits of the received call |
| oor_enter | input | 1 | Strobe: fade recovery or carrier-off entered |
| preamble_det | input | 1 | Strobe: preamble detected |
| sync_det | input | 1 | Strobe: valid sync word detected |
| rx_en | input | 1 | Receiver enable level |
| rd_start | input | 1 | Strobe: host status read begins |
| rd_end | input | 1 | Strobe: host status read completes |
| stat_word | output | STAT_W | Primary status word |
| irq | output | 1 | Interrupt, active high |

## Verification
The bench builds the block with `STAT_W = 4` and `OOR_BIT = 2`. At this size every call word can be swept, and so can every ordered pair of a loaded word and a buffered word. This covers promotion, clearing of the secondary stage and interrupt timing for all values. The small width also keeps each out-of-range sequence short: entering, clearing by preamble or by sync, the enter-wins collision, a deferred report and a receiver fall with no change. Events that coincide with `rd_start` or `rd_end` are exercised both with and without a buffered word.

// File: rtl/pis_pkg.sv
package pis_pkg;
  typedef enum logic [1:0] {
    RT_NONE    = 2'd0,
    RT_PRIMARY = 2'd1,
    RT_SECOND  = 2'd2
  } route_e;
endpackage

// File: rtl/pis_oor_track.sv
module pis_oor_track (
  input  logic clk,
  input  logic rst_n,
  input  logic oor_enter,
  input  logic preamble_det,
  input  logic sync_det,
  input  logic rx_en,
  output logic oor_evt,
  output logic oor_new
);
  logic live_q, rep_q, rx_q, rx_fall;

  assign rx_fall = rx_q & ~rx_en;
  assign oor_evt = rx_fall & (live_q != rep_q);
  assign oor_new = rx_fall ? live_q : rep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      rep_q  <= 1'b0;
      rx_q   <= 1'b0;
    end else begin
      rx_q <= rx_en;
      if (oor_enter)                    live_q <= 1'b1;
      else if (preamble_det | sync_det) live_q <= 1'b0;
      if (rx_fall) rep_q <= live_q;
    end
  end

  a_r10_enter_sets: assert property (@(posedge clk) disable iff (!rst_n)
    oor_enter |=> live_q);
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!oor_enter && (preamble_det || sync_det)) |=> !live_q);
  a_r11_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_q && !rx_en) |=> $stable(rep_q));
endmodule

// File: rtl/pis_evt_merge.sv
module pis_evt_merge #(
  parameter int STAT_W  = 8,
  parameter int OOR_BIT = 5
) (
  input  logic              call_valid,
  input  logic [STAT_W-1:0] call_bits,
  input  logic              oor_evt,
  input  logic              oor_new,
  output logic              ev,
  output logic [STAT_W-1:0] ev_word
);
  localparam logic [STAT_W-1:0] OOR_MASK = STAT_W'(1) << OOR_BIT;

  logic [STAT_W-1:0] call_part, flag_part;

  assign call_part = call_valid ? (call_bits & ~OOR_MASK) : '0;
  assign flag_part = oor_new ? OOR_MASK : '0;
  assign ev        = call_valid | oor_evt;
  assign ev_word   = call_part | flag_part;
endmodule

// File: rtl/pis_stage.sv
module pis_stage
  import pis_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev,
  input  logic [STAT_W-1:0] ev_word,
  input  logic              rd_start,
  input  logic              rd_end,
  output logic [STAT_W-1:0] prim_q,
  output logic              kick_q
);
  logic [STAT_W-1:0] sec_q;
  logic              pend_q, busy_q, in_read_q, hold;
  route_e            route;

  assign hold = busy_q | in_read_q | rd_start;

  always_comb begin
    route = RT_NONE;
    if (ev) begin
      if (rd_end) route = pend_q ? RT_SECOND : RT_PRIMARY;
      else        route = hold   ? RT_SECOND : RT_PRIMARY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q    <= '0;
      sec_q     <= '0;
      pend_q    <= 1'b0;
      busy_q    <= 1'b0;
      in_read_q <= 1'b0;
      kick_q    <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      if (rd_end)        in_read_q <= 1'b0;
      else if (rd_start) in_read_q <= 1'b1;
      if (rd_end) begin
        if (pend_q) begin
          prim_q <= sec_q;
          busy_q <= 1'b1;
          kick_q <= 1'b1;
          pend_q <= 1'b0;
          sec_q  <= '0;
        end else begin
          busy_q <= 1'b0;
        end
      end
      case (route)
        RT_PRIMARY: begin
          prim_q <= ev_word;
          busy_q <= 1'b1;
          kick_q <= 1'b1;
        end
        RT_SECOND: begin
          sec_q  <= ev_word;
          pend_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  a_r5_promote: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && pend_q) |=> (prim_q == $past(sec_q)));
  a_r5_sec_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && pend_q && !ev) |=> !pend_q);
  a_r3_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !rd_end && hold) |=> (pend_q && sec_q == $past(ev_word)
                                 && $stable(prim_q)));
  a_r8_idle_end: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && !pend_q && !ev) |=> $stable(prim_q));
endmodule

// File: rtl/pis_irq.sv
module pis_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic kick,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq <= 1'b0;
    else if (rd_start) irq <= 1'b0;
    else if (kick)     irq <= 1'b1;
  end

  a_r6_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !irq);
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(kick));
endmodule

// File: rtl/pend_irq_stat.sv
module pend_irq_stat #(
  parameter int STAT_W  = 8,
  parameter int OOR_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_valid,
  output logic              call_ready,
  input  logic [STAT_W-1:0] call_bits,
  input  logic              oor_enter,
  input  logic              preamble_det,
  input  logic              sync_det,
  input  logic              rx_en,
  input  logic              rd_start,
  input  logic              rd_end,
  output logic [STAT_W-1:0] stat_word,
  output logic              irq
);
  logic              oor_evt, oor_new, ev, kick;
  logic [STAT_W-1:0] ev_word;

  assign call_ready = 1'b1;

  pis_oor_track u_oor (
    .clk(clk), .rst_n(rst_n), .oor_enter(oor_enter),
    .preamble_det(preamble_det), .sync_det(sync_det), .rx_en(rx_en),
    .oor_evt(oor_evt), .oor_new(oor_new)
  );

  pis_evt_merge #(.STAT_W(STAT_W), .OOR_BIT(OOR_BIT)) u_merge (
    .call_valid(call_valid), .call_bits(call_bits),
    .oor_evt(oor_evt), .oor_new(oor_new), .ev(ev), .ev_word(ev_word)
  );

  pis_stage #(.STAT_W(STAT_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ev_word(ev_word),
    .rd_start(rd_start), .rd_end(rd_end), .prim_q(stat_word), .kick_q(kick)
  );

  pis_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .kick(kick), .irq(irq)
  );

  a_r2_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !rd_start) |=> irq);
  a_r2_event_loads: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(stat_word) |=> (irq || $past(rd_start)));
endmodule

// File: tb/sim_pend_irq_stat.sv
module sim_pend_irq_stat;
  localparam int W = 4;
  localparam int OB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic call_valid = 1'b0, oor_enter = 1'b0, preamble_det = 1'b0, sync_det = 1'b0;
  logic rx_en = 1'b1, rd_start = 1'b0, rd_end = 1'b0;
  logic [W-1:0] call_bits = '0;
  logic call_ready, irq;
  logic [W-1:0] stat_word;
  int total = 0, fails = 0;
  logic oor_m = 1'b0;

  always #5 clk = ~clk;

  pend_irq_stat #(.STAT_W(W), .OOR_BIT(OB)) u0 (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_ready(call_ready),
    .call_bits(call_bits), .oor_enter(oor_enter), .preamble_det(preamble_det),
    .sync_det(sync_det), .rx_en(rx_en), .rd_start(rd_start), .rd_end(rd_end),
    .stat_word(stat_word), .irq(irq)
  );

  function automatic logic [W-1:0] mk(input logic [W-1:0] w);
    return (w & ~(W'(1) << OB)) | (W'(oor_m) << OB);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic do_call(input logic [W-1:0] w);
    call_valid = 1'b1; call_bits = w; tick(); call_valid = 1'b0;
  endtask
  task automatic rd_s; rd_start = 1'b1; tick(); rd_start = 1'b0; endtask
  task automatic rd_e; rd_end = 1'b1; tick(); rd_end = 1'b0; endtask
  task automatic rd_both; rd_s(); rd_e(); endtask
  task automatic fall_rx; rx_en = 1'b0; tick(); rx_en = 1'b1; endtask
  task automatic pulse_enter; oor_enter = 1'b1; tick(); oor_enter = 1'b0; endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1 stat", int'(stat_word), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R12 ready", int'(call_ready), 1);
    rst_n = 1'b1;
    tick();

    // R2, R6, R8: every word loaded from idle
    for (int w = 0; w < 16; w++) begin
      do_call(W'(w));
      chk("R2 load", int'(stat_word), int'(mk(W'(w))));
      chk("R2 irq low", int'(irq), 0);
      tick();
      chk("R2 irq rise", int'(irq), 1);
      rd_s();
      chk("R6 read drop", int'(irq), 0);
      rd_e();
      chk("R8 hold", int'(stat_word), int'(mk(W'(w))));
      tick();
      chk("R8 irq stays low", int'(irq), 0);
    end

    // R3, R5, R6: all ordered pairs
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_call(W'(a)); tick();
        do_call(W'(b));
        chk("R3 primary kept", int'(stat_word), int'(mk(W'(a))));
        rd_s(); rd_e();
        chk("R5 promoted", int'(stat_word), int'(mk(W'(b))));
        chk("R6 low after promote", int'(irq), 0);
        tick();
        chk("R6 rise after promote", int'(irq), 1);
        rd_both();
        chk("R5 secondary empty", int'(stat_word), int'(mk(W'(b))));
        tick();
        chk("R5 no reinterrupt", int'(irq), 0);
      end
    end

    // R7 last pending wins
    do_call(4'd1); do_call(4'd2); do_call(4'd3);
    rd_both();
    chk("R7 last wins", int'(stat_word), int'(mk(4'd3)));
    rd_both();

    // R4 event during read
    do_call(4'd5); tick();
    rd_s();
    do_call(4'd9);
    chk("R4 during read", int'(stat_word), int'(mk(4'd5)));
    rd_e();
    chk("R4 promoted", int'(stat_word), int'(mk(4'd9)));
    rd_both();
    // R4 event in rd_start cycle
    rd_start = 1'b1; call_valid = 1'b1; call_bits = 4'd11; tick();
    rd_start = 1'b0; call_valid = 1'b0;
    chk("R4 start cycle", int'(stat_word), int'(mk(4'd9)));
    rd_e();
    chk("R4 start promoted", int'(stat_word), int'(mk(4'd11)));
    rd_both();

    // R9 event on rd_end with a buffered word
    do_call(4'd1); do_call(4'd6); rd_s();
    rd_end = 1'b1; call_valid = 1'b1; call_bits = 4'd10; tick();
    rd_end = 1'b0; call_valid = 1'b0;
    chk("R9 old promoted", int'(stat_word), int'(mk(4'd6)));
    rd_both();
    chk("R9 new kept", int'(stat_word), int'(mk(4'd10)));
    rd_both();
    // R9 event on rd_end with nothing buffered
    rd_s();
    rd_end = 1'b1; call_valid = 1'b1; call_bits = 4'd12; tick();
    rd_end = 1'b0; call_valid = 1'b0;
    chk("R9 direct load", int'(stat_word), int'(mk(4'd12)));
    tick();
    chk("R9 irq", int'(irq), 1);
    rd_both();

    // R10, R11 out-of-range
    pulse_enter();
    fall_rx(); oor_m = 1'b1;
    chk("R11 set event", int'(stat_word), 4);
    tick();
    chk("R11 irq", int'(irq), 1);
    rd_both();
    do_call(4'd3);
    chk("R12 flag in call", int'(stat_word), 7);
    rd_both();
    sync_det = 1'b1; tick(); sync_det = 1'b0;
    fall_rx(); oor_m = 1'b0;
    chk("R10 sync clears", int'(stat_word), 0);
    rd_both();
    fall_rx(); tick();
    chk("R11 no change no irq", int'(irq), 0);
    pulse_enter(); fall_rx(); oor_m = 1'b1;
    chk("R10 enter", int'(stat_word), 4);
    rd_both();
    preamble_det = 1'b1; tick(); preamble_det = 1'b0;
    fall_rx(); oor_m = 1'b0;
    chk("R10 preamble clears", int'(stat_word), 0);
    rd_both();
    oor_enter = 1'b1; sync_det = 1'b1; tick();
    oor_enter = 1'b0; sync_det = 1'b0;
    fall_rx(); oor_m = 1'b1;
    chk("R10 enter wins", int'(stat_word), 4);
    rd_both();
    sync_det = 1'b1; tick(); sync_det = 1'b0;
    do_call(4'd0);
    chk("R11 deferred", int'(stat_word), 4);
    rd_both();
    fall_rx(); oor_m = 1'b0;
    chk("R11 report on fall", int'(stat_word), 0);
    rd_both();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule